// File: doc/BRIEF.md
# Persistent Interrupt Break Notifier

This block keeps a host-visible status register of latched interrupt flags and a host-writable control register with one enable bit per interrupt source. Other blocks hand it single-cycle event pulses; the block latches them and decides when to raise a one-cycle break request toward the host-side serial logic, which turns that request into the actual break signalling.

Once a break has gone out, the block keeps nagging. Each complete host frame is reported with a flag that says whether it read the status register. If a frame ends without that read, another break is requested straight away. A status read clears every flag at once and ends the nagging. Events that arrive while a frame is in progress are merged into one request at the end of that frame. A pulse on the configuration-load input, given after a power-on break or a soft reset command, reloads the default enables and the mode field from a configuration byte.

Top module: `brk_notifier`

## Requirements
- R1: While rst_ni is low and after it is released, ctl_rdata_o, stat_rdata_o and brk_o are all zero.
- R2: A cycle with cfg_load_i high sets, from the next cycle on, every enable bit ctl_rdata_o[N_SRC-1:0] to cfg_i[0] and both mode fields (ctl_rdata_o and stat_rdata_o bits [N_SRC+1:N_SRC]) to cfg_i[2:1]. In the same step it clears all status flags and any pending or repeating break, and brk_o is low in the next cycle.
- R3: When ctl_wr_i is high, ctl_rdata_o equals ctl_wdata_i from the next cycle on. If cfg_load_i is high in the same cycle, the load wins.
- R4: Status flag k (stat_rdata_o[k]) is set in the cycle after evt_i[k] is high, whatever enable bit k holds. It stays set until a status read or a configuration load.
- R5: If no frame is active, an event on a source that is enabled and whose flag is clear raises brk_o for exactly one cycle, in the cycle after the event.
- R6: An event on a disabled source, or on a source whose flag is already set, requests no break of its own.
- R7: Enabled events that arrive while frame_act_i is high produce no break during the frame. They produce a single brk_o pulse in the cycle after frame_done_i.
- R8: After a break, every frame that ends with frame_done_i high and frame_stat_i low raises brk_o in the next cycle. This repeats until the status register is read.
- R9: A cycle with stat_rd_i high clears all status flags from the next cycle on, except flags whose events arrive in that same cycle. It also stops the repetition.
- R10: An enabled event in the same cycle as stat_rd_i keeps its flag set and leads to a new break at the next frame boundary, or in the next cycle if no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load defaults from cfg_i |
| cfg_i | input | 8 | Configuration byte: bit 0 is the default enable, bits 2:1 the mode |
| ctl_wr_i | input | 1 | Host write of the control register |
| ctl_wdata_i | input | N_SRC+2 | Control write data: mode in the top two bits, enables below |
| ctl_rdata_o | output | N_SRC+2 | Control register contents |
| stat_rd_i | input | 1 | Host read of the status register (clears the flags) |
| stat_rdata_o | output | N_SRC+2 | Status register: mode in the top two bits, flags below |
| evt_i | input | N_SRC | Event pulses, one per source |
| frame_act_i | input | 1 | Host frame in progress |
| frame_done_i | input | 1 | Last cycle of a complete host frame |
| frame_stat_i | input | 1 | The ending frame read the status register |
| brk_o | output | 1 | One-cycle break request |

## Verification
A lost pending request shows up as a missing brk_o pulse, either in the cycle after an idle event or in the cycle after the frame_done_i that should have carried it. A stuck repeat state shows up as a pulse after a frame that read status, or as no pulse after a frame that did not. A wrong flag shows up on stat_rdata_o in the very next cycle. The bench compares all three outputs with a model on every cycle, so any divergence is reported within one clock of its cause. Same-cycle collisions are driven on purpose: events together with reads, loads together with writes, and events on flags that are already set.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned CFG_W        = 8;
  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned CFG_MODE_LSB = 1;
  localparam int unsigned MODE_W       = 2;
endpackage

// File: rtl/brk_ctl_regs.sv
module brk_ctl_regs
  import brk_pkg::*;
#(
  parameter int unsigned N_SRC = 6,
  localparam int unsigned REG_W = N_SRC + MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [N_SRC-1:0]  en_o,
  output logic [REG_W-1:0]  ctl_o,
  output logic [MODE_W-1:0] stat_mode_o
);
  logic [N_SRC-1:0]  en_q;
  logic [MODE_W-1:0] mode_q, smode_q;
  logic [MODE_W-1:0] cfg_mode;

  assign cfg_mode = cfg_i[CFG_MODE_LSB +: MODE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      mode_q  <= '0;
      smode_q <= '0;
    end else if (cfg_load_i) begin
      en_q    <= {N_SRC{cfg_i[CFG_EN_BIT]}};
      mode_q  <= cfg_mode;
      smode_q <= cfg_mode;
    end else if (wr_i) begin
      en_q    <= wdata_i[N_SRC-1:0];
      mode_q  <= wdata_i[REG_W-1:N_SRC];
    end
  end

  assign en_o        = en_q;
  assign ctl_o       = {mode_q, en_q};
  assign stat_mode_o = smode_q;
endmodule

// File: rtl/brk_stat_regs.sv
module brk_stat_regs #(
  parameter int unsigned N_SRC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_load_i,
  input  logic             rd_i,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_SRC-1:0] flags_o,
  output logic             trig_o
);
  logic [N_SRC-1:0] flags_q, kept, fresh;

  // flags surviving this cycle's read
  assign kept  = rd_i ? '0 : flags_q;
  assign fresh = evt_i & en_i & ~kept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flags_q <= '0;
    else if (cfg_load_i) flags_q <= '0;
    else                 flags_q <= kept | evt_i;
  end

  assign flags_o = flags_q;
  assign trig_o  = |fresh;
endmodule

// File: rtl/brk_issue.sv
module brk_issue (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_load_i,
  input  logic rd_i,
  input  logic trig_i,
  input  logic frame_act_i,
  input  logic frame_done_i,
  input  logic frame_stat_i,
  output logic brk_o
);
  logic pend_q, nag_q, brk_q;
  logic pend_eff, nag_eff, want, at_end, idle, issue;

  assign pend_eff = pend_q & ~rd_i;
  assign nag_eff  = nag_q & ~rd_i;
  assign want     = pend_eff | trig_i;
  assign at_end   = frame_done_i & (want | (~frame_stat_i & nag_eff));
  assign idle     = ~frame_act_i & ~frame_done_i & want;
  assign issue    = ~cfg_load_i & (at_end | idle);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      nag_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else if (cfg_load_i) begin
      pend_q <= 1'b0;
      nag_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      pend_q <= want & ~issue;
      nag_q  <= issue | nag_eff;
      brk_q  <= issue;
    end
  end

  assign brk_o = brk_q;
endmodule

// File: rtl/brk_notifier.sv
module brk_notifier
  import brk_pkg::*;
#(
  parameter int unsigned N_SRC = 6,
  localparam int unsigned REG_W = N_SRC + MODE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_load_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             ctl_wr_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  output logic [REG_W-1:0] ctl_rdata_o,
  input  logic             stat_rd_i,
  output logic [REG_W-1:0] stat_rdata_o,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             frame_act_i,
  input  logic             frame_done_i,
  input  logic             frame_stat_i,
  output logic             brk_o
);
  logic [N_SRC-1:0]  en, flags;
  logic [MODE_W-1:0] smode;
  logic              trig;

  brk_ctl_regs #(.N_SRC(N_SRC)) u_ctl (
    .clk_i, .rst_ni, .cfg_load_i, .cfg_i,
    .wr_i(ctl_wr_i), .wdata_i(ctl_wdata_i),
    .en_o(en), .ctl_o(ctl_rdata_o), .stat_mode_o(smode)
  );

  brk_stat_regs #(.N_SRC(N_SRC)) u_stat (
    .clk_i, .rst_ni, .cfg_load_i, .rd_i(stat_rd_i),
    .evt_i, .en_i(en), .flags_o(flags), .trig_o(trig)
  );

  brk_issue u_issue (
    .clk_i, .rst_ni, .cfg_load_i, .rd_i(stat_rd_i), .trig_i(trig),
    .frame_act_i, .frame_done_i, .frame_stat_i, .brk_o
  );

  assign stat_rdata_o = {smode, flags};
endmodule

// File: rtl/brk_notifier_chk.sv
module brk_notifier_chk
  import brk_pkg::*;
#(
  parameter int unsigned N_SRC = 6,
  localparam int unsigned REG_W = N_SRC + MODE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_load_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic             ctl_wr_i,
  input logic [REG_W-1:0] ctl_wdata_i,
  input logic [REG_W-1:0] ctl_rdata_o,
  input logic             stat_rd_i,
  input logic [REG_W-1:0] stat_rdata_o,
  input logic [N_SRC-1:0] evt_i,
  input logic             frame_act_i,
  input logic             frame_done_i,
  input logic             frame_stat_i,
  input logic             brk_o
);
  // R2
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> (stat_rdata_o[N_SRC-1:0] == '0) && !brk_o &&
      (ctl_rdata_o[N_SRC-1:0] == {N_SRC{$past(cfg_i[CFG_EN_BIT])}}));
  // R3
  ctl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !cfg_load_i) |=> ctl_rdata_o == $past(ctl_wdata_i));
  // R4
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_load_i && evt_i != '0) |=>
      (stat_rdata_o[N_SRC-1:0] & $past(evt_i)) == $past(evt_i));
  // R5
  idle_brk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_load_i && !stat_rd_i && !frame_act_i && !frame_done_i &&
     ((evt_i & ctl_rdata_o[N_SRC-1:0] & ~stat_rdata_o[N_SRC-1:0]) != '0)) |=> brk_o);
  // R7
  brk_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> $past(frame_done_i || !frame_act_i));
  // R9
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && evt_i == '0) |=> stat_rdata_o[N_SRC-1:0] == '0);
  // R6
  brk_has_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> stat_rdata_o[N_SRC-1:0] != '0);
endmodule

bind brk_notifier brk_notifier_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i, .rst_ni, .cfg_load_i, .cfg_i, .ctl_wr_i, .ctl_wdata_i, .ctl_rdata_o,
  .stat_rd_i, .stat_rdata_o, .evt_i, .frame_act_i, .frame_done_i,
  .frame_stat_i, .brk_o
);

// File: tb/brk_notifier_bench.sv
module brk_notifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam int W = N + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, ctl_wr = 0, stat_rd = 0;
  logic act = 0, done = 0, fstat = 0;
  logic [7:0] cfg = '0;
  logic [W-1:0] wdata = '0;
  logic [N-1:0] evt = '0;
  logic [W-1:0] ctl_rd, stat_rd_v;
  logic brk;

  int checks = 0, fails = 0;

  // model state
  logic [N-1:0] m_en = '0, m_fl = '0;
  logic [1:0]   m_mode = '0, m_smode = '0;
  logic m_pend = 0, m_nag = 0, m_brk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_notifier #(.N_SRC(N)) u_brk_notifier (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_i(cfg),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(wdata), .ctl_rdata_o(ctl_rd),
    .stat_rd_i(stat_rd), .stat_rdata_o(stat_rd_v), .evt_i(evt),
    .frame_act_i(act), .frame_done_i(done), .frame_stat_i(fstat), .brk_o(brk)
  );

  task automatic check(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic idle_in();
    cfg_load = 0; ctl_wr = 0; stat_rd = 0; act = 0; done = 0; fstat = 0; evt = '0;
  endtask

  // next-state model from the requirements
  task automatic model_next();
    logic [N-1:0] kept;
    logic fresh, pe, ne, want, issue;
    kept  = stat_rd ? '0 : m_fl;
    fresh = |(evt & m_en & ~kept);
    pe    = m_pend & ~stat_rd;
    ne    = m_nag & ~stat_rd;
    want  = pe | fresh;
    issue = !cfg_load && ((done && (want || (!fstat && ne))) || (!act && !done && want));
    if (cfg_load) begin
      m_en = {N{cfg[0]}}; m_mode = cfg[2:1]; m_smode = cfg[2:1];
      m_fl = '0; m_pend = 0; m_nag = 0; m_brk = 0;
    end else begin
      if (ctl_wr) begin m_en = wdata[N-1:0]; m_mode = wdata[W-1:N]; end
      m_fl = kept | evt; m_pend = want & ~issue; m_nag = issue | ne; m_brk = issue;
    end
  endtask

  task automatic step(input string tag);
    model_next();
    @(negedge clk);
    check({tag, " brk"}, 32'(brk), 32'(m_brk));
    check({tag, " ctl"}, 32'(ctl_rd), 32'({m_mode, m_en}));
    check({tag, " stat"}, 32'(stat_rd_v), 32'({m_smode, m_fl}));
    idle_in();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_1234);
    idle_in();
    repeat (3) @(negedge clk);
    check("R1 rst brk", 32'(brk), 0);
    check("R1 rst ctl", 32'(ctl_rd), 0);
    check("R1 rst stat", 32'(stat_rd_v), 0);
    rst_n = 1;
    step("R1 after release");

    // R2: load defaults, enables all set, mode 2'b10
    cfg_load = 1; cfg = 8'h05; step("R2 load");
    check("R2 ctl", 32'(ctl_rd), 32'({2'b10, 6'h3f}));
    // R3: write, then load beats write
    ctl_wr = 1; wdata = {2'b01, 6'b001011}; step("R3 write");
    check("R3 readback", 32'(ctl_rd), 32'({2'b01, 6'b001011}));
    ctl_wr = 1; wdata = '0; cfg_load = 1; cfg = 8'h05; step("R3 load wins");
    check("R3 load wins", 32'(ctl_rd), 32'({2'b10, 6'h3f}));

    // R5: idle enabled event gives one pulse
    evt = 6'b000001; step("R5 evt");
    check("R5 brk", 32'(brk), 1);
    check("R4 flag", 32'(stat_rd_v[0]), 1);
    step("R5 single");
    check("R5 one cycle", 32'(brk), 0);
    // R6: event on already-set flag
    evt = 6'b000001; step("R6 repeat evt");
    check("R6 no brk", 32'(brk), 0);
    // R8: frames without status read
    for (int f = 0; f < 3; f++) begin
      act = 1; step("R8 frame");
      act = 1; done = 1; step("R8 end");
      check("R8 reissue", 32'(brk), 1);
    end
    // R9: frame that reads status
    act = 1; stat_rd = 1; step("R9 read");
    check("R9 cleared", 32'(stat_rd_v[N-1:0]), 0);
    act = 1; done = 1; fstat = 1; step("R9 end");
    check("R9 no brk", 32'(brk), 0);
    act = 1; done = 1; step("R9 next frame");
    check("R9 stopped", 32'(brk), 0);

    // R6: disabled source latches silently
    ctl_wr = 1; wdata = {2'b00, 6'b111110}; step("R6 disable0");
    evt = 6'b000001; step("R6 disabled evt");
    check("R6 latched", 32'(stat_rd_v[0]), 1);
    check("R6 no brk", 32'(brk), 0);
    stat_rd = 1; step("R6 clear");

    // R7: mid-frame events merged
    act = 1; evt = 6'b000010; step("R7 mid1");
    act = 1; evt = 6'b000100; step("R7 mid2");
    check("R7 none mid", 32'(brk), 0);
    act = 1; done = 1; step("R7 end");
    check("R7 single", 32'(brk), 1);
    step("R7 after");
    check("R7 one only", 32'(brk), 0);

    // R10: event in the read cycle is kept
    stat_rd = 1; evt = 6'b001000; step("R10 collide");
    check("R10 kept", 32'(stat_rd_v[N-1:0]), 32'(6'b001000));
    check("R10 brk", 32'(brk), 1);

    // random phase
    for (int f = 0; f < 1500; f++) begin
      int gap, len, rdat;
      gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        if ($urandom_range(0, 3) == 0) evt = N'($urandom);
        if ($urandom_range(0, 15) == 0) begin ctl_wr = 1; wdata = W'($urandom); end
        if ($urandom_range(0, 63) == 0) begin cfg_load = 1; cfg = 8'($urandom); end
        step("R4 rand idle");
      end
      len  = $urandom_range(1, 5);
      rdat = $urandom_range(0, len - 1);
      fstat = 0;
      for (int c = 0; c < len; c++) begin
        act = 1;
        if ($urandom_range(0, 2) == 0) evt = N'($urandom);
        if (c == rdat && f % 3 == 0) stat_rd = 1;
        if (c == len - 1) begin done = 1; fstat = (f % 3 == 0); end
        step("R8 rand frame");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule